// File: doc/BRIEF.md
# Embedded Flash Array Controller

This block sits between a simple 32-bit register bus and a small word-organised non-volatile array, which here is a synthesizable RAM that comes up holding all ones. Software picks an operation through a mode field, gives a word address, opens the key gate and fires a start bit. The controller then either clears one sector back to all ones or takes in a stream of words and merges each one into the array.

An erase holds the busy flag for a programmable number of cycles and rewrites every word of the sector that contains the given address. A program burst takes its first word before the start. Each later word is accepted through a single-word holding buffer, whose empty flag software polls before it writes the next word. After the last word of the burst is committed, busy falls. A protection mask shields a region at the bottom of the array from both kinds of operation. A sticky bit in that mask freezes the mask until reset. A register-read mode returns the array word at the current address through a read-data register.

Top module: `flashctl_top`

## Requirements
- R1: After reset the status register (offset 0x14) reads 0x4: bit 2 is buffer-empty (1 = empty), bit 1 is busy (1 = busy), and bit 0 reads 0. Every array word reads 0xFFFFFFFF.
- R2: Registers read back what was written, trimmed to their fields. The control register at 0x00 keeps all 32 bits. The word-address register at 0x04 keeps the low log2(ARRAY_WORDS) bits. The erase-timing register at 0x24 keeps bits [30:0], and its erase count is bits [18:0]. The program-timing register at 0x28 keeps bits [21:0], and its per-word count is bits [10:0].
- R3: A start is accepted only while the gate is open. Writing 0xAA in the low byte of offset 0x1C opens the gate, and writing 0x55 in the low byte of offset 0x18 closes it. A start on a closed gate leaves busy low and the array unchanged. A wrong key leaves the gate as it was.
- R4: With mode 2 (control bits [4:2]), a start (bit 0 written 1 at offset 0x10) sets every word of the 128-word sector that holds the address to 0xFFFFFFFF. Busy stays high for the erase count in cycles, or for 128 cycles if the count is smaller.
- R5: With mode 1, a start commits the word already in the data register (0x08) at the address, and then one word at each following address, 64 words in all. Each word takes the per-word count in cycles (at least 1). Buffer-empty goes back to 1 only when a word is committed, and busy falls after the 64th word.
- R6: A program write ANDs the new data into the stored word, so stored bits can only go from 1 to 0.
- R7: Mask bits [1:0] (offset 0x20) protect the words below 0, 512, 1024 or 2048 for the values 0 to 3. Erase or program writes that fall in that region leave the array unchanged. Busy still runs its normal course.
- R8: Once a mask value with bit 2 set has been written, later writes to the mask register are ignored until reset.
- R9: An accepted mask write raises busy for 4 cycles.
- R10: A start that arrives while busy is ignored and does not lengthen the running operation.
- R11: In mode 5 the read-data register (0x0C) returns the array word at the current address. In any other mode it reads 0.
- R12: A start in a mode other than 1 or 2 does nothing, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational on busAddr |

## Verification
A wrong internal state surfaces at the ports within a few cycles, or at the end of an operation. A broken busy counter changes the measured busy length of an erase or a mask settle. A pointer or merge fault leaves wrong words that register-read mode exposes right after the burst. A lock or protection fault shows at once, either as a busy flag that should have stayed low or as an array word that changed when it should have stayed. The bench keeps its own model of the array and compares every word of each burst, and the words at the sector edges, against that model.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

  localparam int unsigned OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_CTRL    = 8'h00;
  localparam logic [OFS_W-1:0] OFS_ADDR    = 8'h04;
  localparam logic [OFS_W-1:0] OFS_WDATA   = 8'h08;
  localparam logic [OFS_W-1:0] OFS_RDATA   = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_GO      = 8'h10;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 8'h14;
  localparam logic [OFS_W-1:0] OFS_CLOSE   = 8'h18;
  localparam logic [OFS_W-1:0] OFS_OPEN    = 8'h1C;
  localparam logic [OFS_W-1:0] OFS_PROT    = 8'h20;
  localparam logic [OFS_W-1:0] OFS_ETIME   = 8'h24;
  localparam logic [OFS_W-1:0] OFS_PTIME   = 8'h28;

  localparam logic [7:0] KEY_OPEN  = 8'hAA;
  localparam logic [7:0] KEY_CLOSE = 8'h55;

  localparam logic [2:0] MODE_BUSREAD = 3'd0;
  localparam logic [2:0] MODE_PROG    = 3'd1;
  localparam logic [2:0] MODE_ERASE   = 3'd2;
  localparam logic [2:0] MODE_REGREAD = 3'd5;

  localparam int unsigned ERASE_T_W = 19;
  localparam int unsigned RECOV_W   = 12;
  localparam int unsigned PROG_T_W  = 11;
  localparam int unsigned SETUP_W   = 11;
  localparam int unsigned ETIME_W   = ERASE_T_W + RECOV_W;
  localparam int unsigned PTIME_W   = PROG_T_W + SETUP_W;

  // control -> datapath
  typedef struct packed {
    logic loadPtr;
    logic alignSector;
    logic eraseWr;
    logic progWr;
  } strobe_t;

  // datapath -> control: accepted bus events
  typedef struct packed {
    logic goWr;
    logic unlockWr;
    logic lockWr;
    logic maskWr;
    logic dataWr;
  } busEvt_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ERASE,
    PH_PROG,
    PH_SETTLE
  } phase_e;

endpackage

// File: rtl/flashctl_datapath.sv
module flashctl_datapath
  import flashctl_pkg::*;
#(
  parameter int ARRAY_WORDS     = 2048,
  parameter int SECTOR_WORDS    = 128,
  parameter int PROT_UNIT_WORDS = 512
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic [OFS_W-1:0]     busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output busEvt_t              evt,
  output logic [2:0]           opMode,
  output logic [ERASE_T_W-1:0] eraseCycles,
  output logic [PROG_T_W-1:0]  progCycles,
  input  strobe_t              strb,
  input  logic                 busy,
  input  logic                 bufEmpty
);

  localparam int ADDR_W = $clog2(ARRAY_WORDS);
  localparam logic [ADDR_W-1:0] SECTOR_LOW = ADDR_W'(SECTOR_WORDS - 1);

  logic [31:0]        cfgReg;
  logic [31:0]        wrDataReg;
  logic [ADDR_W-1:0]  wordAddr;
  logic [ADDR_W-1:0]  opPtr;
  logic [2:0]         maskReg;
  logic [ETIME_W-1:0] eraseTimeReg;
  logic [PTIME_W-1:0] progTimeReg;
  logic [31:0]        protLimit;
  logic               ptrProt;
  logic [31:0]        cells [ARRAY_WORDS];

  // bus decode into accepted events
  always_comb begin
    evt.goWr     = busWr && (busAddr == OFS_GO) && busWdata[0];
    evt.unlockWr = busWr && (busAddr == OFS_OPEN) && (busWdata[7:0] == KEY_OPEN);
    evt.lockWr   = busWr && (busAddr == OFS_CLOSE) && (busWdata[7:0] == KEY_CLOSE);
    evt.maskWr   = busWr && (busAddr == OFS_PROT) && !maskReg[2];
    evt.dataWr   = busWr && (busAddr == OFS_WDATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg       <= '0;
      wrDataReg    <= '0;
      wordAddr     <= '0;
      maskReg      <= '0;
      eraseTimeReg <= '0;
      progTimeReg  <= '0;
    end else begin
      if (busWr && busAddr == OFS_CTRL)  cfgReg       <= busWdata;
      if (busWr && busAddr == OFS_ADDR)  wordAddr     <= busWdata[ADDR_W-1:0];
      if (evt.dataWr)                    wrDataReg    <= busWdata;
      if (evt.maskWr)                    maskReg      <= busWdata[2:0];
      if (busWr && busAddr == OFS_ETIME) eraseTimeReg <= busWdata[ETIME_W-1:0];
      if (busWr && busAddr == OFS_PTIME) progTimeReg  <= busWdata[PTIME_W-1:0];
    end
  end

  assign opMode      = cfgReg[4:2];
  assign eraseCycles = eraseTimeReg[ERASE_T_W-1:0];
  assign progCycles  = progTimeReg[PROG_T_W-1:0];

  // operation pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opPtr <= '0;
    end else if (strb.loadPtr) begin
      opPtr <= strb.alignSector ? (wordAddr & ~SECTOR_LOW) : wordAddr;
    end else if (strb.eraseWr || strb.progWr) begin
      opPtr <= opPtr + 1'b1;
    end
  end

  // protected region: words below PROT_UNIT_WORDS << (sel-1)
  always_comb begin
    if (maskReg[1:0] == 2'd0) protLimit = '0;
    else protLimit = 32'(PROT_UNIT_WORDS) << (maskReg[1:0] - 2'd1);
    ptrProt = (32'(opPtr) < protLimit);
  end

  // array storage, preset to all ones
  initial begin
    for (int i = 0; i < ARRAY_WORDS; i++) cells[i] = '1;
  end

  always_ff @(posedge clk) begin
    if ((strb.eraseWr || strb.progWr) && !ptrProt) begin
      cells[opPtr] <= strb.eraseWr ? '1 : (cells[opPtr] & wrDataReg);
    end
  end

  // register readback
  always_comb begin
    case (busAddr)
      OFS_CTRL:   busRdata = cfgReg;
      OFS_ADDR:   busRdata = 32'(wordAddr);
      OFS_WDATA:  busRdata = wrDataReg;
      OFS_RDATA:  busRdata = (opMode == MODE_REGREAD) ? cells[wordAddr] : '0;
      OFS_STATUS: busRdata = {29'd0, bufEmpty, busy, 1'b0};
      OFS_PROT:   busRdata = {29'd0, maskReg};
      OFS_ETIME:  busRdata = 32'(eraseTimeReg);
      OFS_PTIME:  busRdata = 32'(progTimeReg);
      default:    busRdata = '0;
    endcase
  end

  assert_erase_ones_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eraseWr && !ptrProt) |=> (cells[$past(opPtr)] == 32'hFFFF_FFFF));

  assert_prog_and_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.progWr && !ptrProt) |=>
      (cells[$past(opPtr)] == ($past(cells[opPtr]) & $past(wrDataReg))));

  assert_protect_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.eraseWr || strb.progWr) && ptrProt) |=>
      (cells[$past(opPtr)] == $past(cells[opPtr])));

  assert_mask_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    maskReg[2] |=> $stable(maskReg));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.progWr && !strb.loadPtr) |=> (opPtr == $past(opPtr) + 1'b1));

endmodule

// File: rtl/flashctl_control.sv
module flashctl_control
  import flashctl_pkg::*;
#(
  parameter int SECTOR_WORDS  = 128,
  parameter int BURST_WORDS   = 64,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busEvt_t              evt,
  input  logic [2:0]           opMode,
  input  logic [ERASE_T_W-1:0] eraseCycles,
  input  logic [PROG_T_W-1:0]  progCycles,
  output strobe_t              strb,
  output logic                 busy,
  output logic                 bufEmpty
);

  localparam int CNT_W   = ERASE_T_W + 1;
  localparam int WCNT_W  = $clog2(BURST_WORDS);
  localparam logic [CNT_W-1:0]  SECTOR_LEN = CNT_W'(SECTOR_WORDS);
  localparam logic [CNT_W-1:0]  SETTLE_LEN = CNT_W'(SETTLE_CYCLES);
  localparam logic [WCNT_W-1:0] LAST_WORD  = WCNT_W'(BURST_WORDS - 1);

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic [WCNT_W-1:0]  wordCnt;
  logic               unlocked;
  logic               bufFull;
  logic [CNT_W-1:0]   eraseLen;
  logic [CNT_W-1:0]   progLen;
  logic               startOk;
  logic               wordDone;

  always_comb begin
    eraseLen = ({1'b0, eraseCycles} < SECTOR_LEN) ? SECTOR_LEN : {1'b0, eraseCycles};
    progLen  = (progCycles == '0) ? CNT_W'(1) : CNT_W'(progCycles);
    startOk  = evt.goWr && unlocked && (phase == PH_IDLE) &&
               ((opMode == MODE_PROG) || (opMode == MODE_ERASE));
    wordDone = (phase == PH_PROG) && bufFull && (cnt == progLen - 1'b1);

    strb.loadPtr     = startOk;
    strb.alignSector = startOk && (opMode == MODE_ERASE);
    strb.eraseWr     = (phase == PH_ERASE) && (cnt < SECTOR_LEN);
    strb.progWr      = wordDone;
  end

  assign busy     = (phase != PH_IDLE);
  assign bufEmpty = !bufFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      bufFull  <= 1'b0;
    end else begin
      if (evt.unlockWr)    unlocked <= 1'b1;
      else if (evt.lockWr) unlocked <= 1'b0;
      if (evt.dataWr)      bufFull  <= 1'b1;
      else if (wordDone)   bufFull  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      wordCnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt     <= '0;
          wordCnt <= '0;
          if (startOk) phase <= (opMode == MODE_ERASE) ? PH_ERASE : PH_PROG;
          else if (evt.maskWr) phase <= PH_SETTLE;
        end
        PH_ERASE: begin
          if (cnt == eraseLen - 1'b1) phase <= PH_IDLE;
          else cnt <= cnt + 1'b1;
        end
        PH_PROG: begin
          if (bufFull) begin
            if (wordDone) begin
              cnt <= '0;
              if (wordCnt == LAST_WORD) phase <= PH_IDLE;
              else wordCnt <= wordCnt + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_SETTLE: begin
          if (cnt == SETTLE_LEN - 1'b1) phase <= PH_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_locked_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evt.goWr && !unlocked && (phase == PH_IDLE) && !evt.maskWr) |=> !busy);

  assert_busy_no_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    (evt.goWr && (phase == PH_ERASE) && (cnt != eraseLen - 1'b1)) |=>
      (cnt == $past(cnt) + 1'b1));

  assert_empty_after_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> $past(strb.progWr));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadPtr, strb.eraseWr, strb.progWr}));

  assert_bad_mode_R12: assert property (@(posedge clk) disable iff (!rstN)
    (evt.goWr && (phase == PH_IDLE) && !evt.maskWr &&
     (opMode != MODE_PROG) && (opMode != MODE_ERASE)) |=> !busy);

endmodule

// File: rtl/flashctl_top.sv
module flashctl_top
  import flashctl_pkg::*;
#(
  parameter int ARRAY_WORDS     = 2048,
  parameter int SECTOR_WORDS    = 128,
  parameter int BURST_WORDS     = 64,
  parameter int PROT_UNIT_WORDS = 512,
  parameter int SETTLE_CYCLES   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);

  busEvt_t              evt;
  strobe_t              strb;
  logic [2:0]           opMode;
  logic [ERASE_T_W-1:0] eraseCycles;
  logic [PROG_T_W-1:0]  progCycles;
  logic                 busy;
  logic                 bufEmpty;

  flashctl_datapath #(
    .ARRAY_WORDS    (ARRAY_WORDS),
    .SECTOR_WORDS   (SECTOR_WORDS),
    .PROT_UNIT_WORDS(PROT_UNIT_WORDS)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .evt        (evt),
    .opMode     (opMode),
    .eraseCycles(eraseCycles),
    .progCycles (progCycles),
    .strb       (strb),
    .busy       (busy),
    .bufEmpty   (bufEmpty)
  );

  flashctl_control #(
    .SECTOR_WORDS (SECTOR_WORDS),
    .BURST_WORDS  (BURST_WORDS),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evt),
    .opMode     (opMode),
    .eraseCycles(eraseCycles),
    .progCycles (progCycles),
    .strb       (strb),
    .busy       (busy),
    .bufEmpty   (bufEmpty)
  );

endmodule

// File: tb/flashctl_top_bench.sv
`timescale 1ns/1ps
module flashctl_top_bench;

  localparam logic [7:0] A_CTRL = 8'h00, A_ADDR = 8'h04, A_WDATA = 8'h08, A_RDATA = 8'h0C,
                         A_GO = 8'h10, A_STAT = 8'h14, A_CLOSE = 8'h18, A_OPEN = 8'h1C,
                         A_PROT = 8'h20, A_ETIME = 8'h24, A_PTIME = 8'h28;
  localparam logic [31:0] M_PROG = 32'h4, M_ERASE = 32'h8, M_RD = 32'h14, M_BUS = 32'h0;
  localparam int NWORDS = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int protModel = 0;
  logic [31:0] model [NWORDS];

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];
  logic rdValid = 1'b0;

  flashctl_top u_flashctl_top (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items and compares mid-phase
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rdValid && expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        checks++;
        if (busRdata !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, busRdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busWr = 1'b0;
  endtask

  task automatic expectReg(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    busAddr = a;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    rdValid = 1'b1;
    @(posedge clk);
    #1 rdValid = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic readWord(input int a, input string tag);
    regWrite(A_CTRL, M_RD);
    regWrite(A_ADDR, a);
    expectReg(A_RDATA, model[a], tag);
  endtask

  task automatic waitIdle(output int doneCyc);
    logic [31:0] s;
    s = 32'h2;
    while (s[1]) peek(A_STAT, s);
    doneCyc = cyc;
  endtask

  function automatic logic [31:0] pat(input int i, input logic [31:0] seed);
    return seed ^ (32'h0101_0101 * i) ^ (32'h1 << (i % 32));
  endfunction

  task automatic progBurst(input int base, input logic [31:0] seed);
    logic [31:0] s;
    int d;
    regWrite(A_CTRL, M_PROG);
    regWrite(A_ADDR, base);
    regWrite(A_WDATA, pat(0, seed));
    regWrite(A_GO, 1);
    peek(A_STAT, s);
    checkVal("R5 busy after program start", s[1], 1);
    for (int i = 1; i < 64; i++) begin
      s = 32'h0;
      while (!s[2]) peek(A_STAT, s);
      regWrite(A_WDATA, pat(i, seed));
    end
    waitIdle(d);
    for (int i = 0; i < 64; i++)
      if (base + i >= protModel) model[base + i] = model[base + i] & pat(i, seed);
  endtask

  task automatic eraseAt(input int a, input int expLen, input bit restart, input string tag);
    int c0, c1;
    regWrite(A_CTRL, M_ERASE);
    regWrite(A_ADDR, a);
    regWrite(A_GO, 1);
    c0 = cyc;
    if (restart) begin
      repeat (10) @(posedge clk);
      regWrite(A_GO, 1);
    end
    waitIdle(c1);
    checkVal(tag, c1 - c0, expLen);
    if ((a / 128) * 128 >= protModel)
      for (int i = 0; i < 128; i++) model[(a / 128) * 128 + i] = 32'hFFFF_FFFF;
  endtask

  initial begin
    logic [31:0] s;
    int c0, c1;
    for (int i = 0; i < NWORDS; i++) model[i] = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expectReg(A_STAT, 32'h4, "R1 status after reset");
    readWord(0, "R1 word 0 erased");
    readWord(2047, "R1 last word erased");

    // R2 readback
    regWrite(A_ETIME, 32'hFFFF_FFFF);
    expectReg(A_ETIME, 32'h7FFF_FFFF, "R2 erase timing field");
    regWrite(A_PTIME, 32'hFFFF_FFFF);
    expectReg(A_PTIME, 32'h003F_FFFF, "R2 program timing field");
    regWrite(A_ADDR, 32'hFFFF_FFFF);
    expectReg(A_ADDR, 32'h0000_07FF, "R2 address width");
    regWrite(A_CTRL, 32'h8000_0017);
    expectReg(A_CTRL, 32'h8000_0017, "R2 control readback");
    regWrite(A_ETIME, 200);
    regWrite(A_PTIME, 3);

    // R3 start on closed gate
    regWrite(A_CTRL, M_PROG);
    regWrite(A_ADDR, 600);
    regWrite(A_WDATA, 32'h0);
    regWrite(A_GO, 1);
    peek(A_STAT, s);
    checkVal("R3 locked start no busy", s[1], 0);
    readWord(600, "R3 locked start array kept");

    // R5 program burst, R6 AND merge
    regWrite(A_OPEN, 32'hAA);
    progBurst(600, 32'h5A5A_0F0F);
    for (int i = 0; i < 65; i++) readWord(600 + i, "R5 burst word");
    progBurst(600, 32'h0FF0_3CC3);
    for (int i = 0; i < 64; i += 7) readWord(600 + i, "R6 AND merge");

    // R4 erase with mid-run start (R10)
    eraseAt(650, 200, 1'b1, "R10 R4 erase busy length with restart");
    readWord(639, "R4 previous sector kept");
    readWord(640, "R4 sector first word");
    readWord(663, "R4 sector inner word");
    readWord(767, "R4 sector last word");
    regWrite(A_ETIME, 10);
    eraseAt(700, 128, 1'b0, "R4 erase length clamp");

    // data to protect later
    progBurst(448, 32'h1234_8765);

    // R9 mask settle, R7 protection
    regWrite(A_PROT, 32'h1);
    c0 = cyc;
    waitIdle(c1);
    checkVal("R9 mask busy length", c1 - c0, 4);
    expectReg(A_PROT, 32'h1, "R7 mask readback");
    protModel = 512;
    eraseAt(450, 128, 1'b0, "R7 protected erase busy length");
    readWord(448, "R7 protected erase kept");
    readWord(511, "R7 protected erase kept end");
    progBurst(0, 32'h0000_0000);
    readWord(0, "R7 protected program kept");
    readWord(63, "R7 protected program kept end");

    // R8 sticky mask
    regWrite(A_PROT, 32'h6);
    waitIdle(c1);
    expectReg(A_PROT, 32'h6, "R8 mask with lock bit");
    regWrite(A_PROT, 32'h0);
    peek(A_STAT, s);
    checkVal("R8 ignored mask write no busy", s[1], 0);
    expectReg(A_PROT, 32'h6, "R8 mask frozen");
    protModel = 1024;
    progBurst(700, 32'h0);
    readWord(700, "R8 frozen 4K region protects");

    // R12 other modes
    regWrite(A_CTRL, M_BUS);
    regWrite(A_GO, 1);
    peek(A_STAT, s);
    checkVal("R12 start in bus-read mode", s[1], 0);
    regWrite(A_CTRL, M_RD);
    regWrite(A_GO, 1);
    peek(A_STAT, s);
    checkVal("R12 start in register-read mode", s[1], 0);

    // R11 read data gating
    regWrite(A_ADDR, 600);
    regWrite(A_CTRL, M_BUS);
    expectReg(A_RDATA, 32'h0, "R11 read data zero outside mode 5");
    readWord(600, "R11 read data in mode 5");

    // R3 wrong key and close
    progBurst(1100, 32'hC0DE_0001);
    regWrite(A_CLOSE, 32'h55);
    regWrite(A_OPEN, 32'hAB);
    regWrite(A_CTRL, M_ERASE);
    regWrite(A_ADDR, 1100);
    regWrite(A_GO, 1);
    peek(A_STAT, s);
    checkVal("R3 closed gate erase ignored", s[1], 0);
    readWord(1100, "R3 closed gate array kept");
    readWord(1163, "R3 closed gate array kept end");

    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule